// File: doc/BRIEF.md
# Serial Tuning-Word Control Port

This block is the control port of a PLL frequency synthesizer. A host drives three wires: a serial data line, a bit clock and an enable strobe. Bits are taken most significant first on each rising edge of the bit clock while the strobe is high. The word is captured when the strobe falls. All three wires are first synchronized into the system clock domain, and every edge is detected after synchronization.

A captured word does not reach the synthesizer at once. It waits in a staging register with a pending flag set, and moves to the active control outputs only when the programmable divider reports the end of a cycle on `div_tick`. The divider ratio therefore changes only at a cycle boundary, and tuning steps are free of glitches. The block counts the bit-clock edges in each strobe window. A word whose count is not exactly the configured length is dropped. It sets no pending flag and leaves the active outputs unchanged. The word length is the port-bit count plus seven control bits plus the ratio width: 28 bits with four port bits and 26 bits with two.

Top module: `synth_ctl_port`

## Requirements
- R1: After reset, every active control output is 0 and `update_pending` is 0.
- R2: Bits enter most significant first on synchronized rising bit-clock edges while the strobe is high. In the captured word, bits [RATIO_W-1:0] form `div_ratio`. The next bit up is `presc_en` (1 enables the divide-by-two prescaler, 0 bypasses it). The next three bits are `ref_sel`, with its MSB highest. Above those come `cp_cur_hi`, `drive_off` and `test_mode`, in that order. The top PORT_N bits form `port_out`.
- R3: Bit-clock edges while the strobe is low shift nothing and are not counted, so they never complete or change a word.
- R4: When the strobe falls after exactly WORD_W bit-clock edges, the word is staged and `update_pending` goes to 1.
- R5: When the strobe falls after any other number of edges, the word is discarded. `update_pending` stays 0 and the active outputs stay unchanged, including after later `div_tick` pulses.
- R6: The staged word is copied to the active outputs only in the cycle after a `div_tick` that arrives while `update_pending` is 1. That load clears `update_pending`.
- R7: The active outputs hold their value in every cycle that does not follow such a load. A `div_tick` with nothing pending changes nothing.
- R8: With PORT_N=2 the word is 26 bits long and `port_out` is 2 bits wide.
- R9: If a second valid word is captured before any `div_tick`, the second word replaces the first, and only the second word is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk | input | 1 | Serial bit clock, asynchronous to clk |
| bus_data | input | 1 | Serial data, MSB first |
| bus_en | input | 1 | Strobe; high frames a word, falling edge captures it |
| div_tick | input | 1 | One-cycle pulse at the programmable divider's cycle boundary |
| div_ratio | output | RATIO_W | Active programmable divider ratio |
| presc_en | output | 1 | Active divide-by-two prescaler enable |
| ref_sel | output | 3 | Active reference-divider select |
| cp_cur_hi | output | 1 | Active charge-pump current select |
| drive_off | output | 1 | Active varactor-drive disable |
| test_mode | output | 1 | Active test-mode enable |
| port_out | output | PORT_N | Active switching-port bits |
| update_pending | output | 1 | A staged word is waiting for the next divider boundary |

## Verification
The bench builds two instances on one shared bus and tick: the default 4-port, 28-bit one and a 2-port, 26-bit one. Each word that is legal for one instance is one of the wrong lengths for the other, so every capture checks both acceptance and rejection. A sweep of 16 words covers every port pattern, every reference select and every control-bit mix, with ratios computed arithmetically. Separate cases cover counts one above and one below the word length, clocks sent with the strobe low, and two words sent back to back before a single tick.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;

  localparam int unsigned CTRL_N = 7;
  localparam int unsigned REF_W  = 3;

  // Control bits between the port field and the ratio field, MSB first.
  typedef struct packed {
    logic             test;
    logic             drv_off;
    logic             cp_hi;
    logic [REF_W-1:0] ref_sel;
    logic             presc;
  } ctl_bits_t;

endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], d_in[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign d_out[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/ctl_shift.sv
module ctl_shift #(
  parameter int unsigned WORD_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_clk,
  input  logic              s_en,
  input  logic              s_dat,
  output logic [WORD_W-1:0] word_q,
  output logic              cap_ok
);

  localparam int unsigned CNT_W   = $clog2(WORD_W + 2);
  localparam int unsigned CNT_MAX = WORD_W + 1;

  logic             clk_prev_q, en_prev_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [WORD_W-1:0] sr_d;
  logic             bit_rise, en_fall;

  always_comb begin
    bit_rise = s_clk && !clk_prev_q && s_en;
    en_fall  = !s_en && en_prev_q;

    cnt_d = cnt_q;
    if (!s_en)
      cnt_d = '0;
    else if (bit_rise && (cnt_q != CNT_W'(CNT_MAX)))
      cnt_d = cnt_q + 1'b1;

    sr_d = word_q;
    if (bit_rise)
      sr_d = {word_q[WORD_W-2:0], s_dat};

    cap_ok = en_fall && (cnt_q == CNT_W'(WORD_W));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_prev_q <= 1'b0;
      en_prev_q  <= 1'b0;
      cnt_q      <= '0;
      word_q     <= '0;
    end else begin
      clk_prev_q <= s_clk;
      en_prev_q  <= s_en;
      cnt_q      <= cnt_d;
      if (bit_rise) word_q <= sr_d;
    end
  end

  // R3: no shift and zero count while the strobe is low
  p_idle_no_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !s_en |=> $stable(word_q));
  p_idle_count_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !s_en |=> (cnt_q == '0));
  // R5: the count saturates above the word length and never wraps
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(CNT_MAX));

endmodule

// File: rtl/ctl_stage.sv
module ctl_stage #(
  parameter int unsigned WORD_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_ok,
  input  logic [WORD_W-1:0] word_in,
  input  logic              div_tick,
  output logic [WORD_W-1:0] active_q,
  output logic              pending_q
);

  logic [WORD_W-1:0] staged_q;
  logic              pending_d;
  logic              load_en;

  always_comb begin
    load_en   = div_tick && pending_q;
    pending_d = pending_q;
    if (cap_ok)       pending_d = 1'b1;
    else if (load_en) pending_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged_q  <= '0;
      active_q  <= '0;
      pending_q <= 1'b0;
    end else begin
      pending_q <= pending_d;
      if (cap_ok)  staged_q <= word_in;
      if (load_en) active_q <= staged_q;
    end
  end

  // R4: a full word raises the pending flag
  p_capture_pends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ok |=> pending_q);
  // R5: without a capture the pending flag never rises
  p_no_pend_without_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending_q && !cap_ok) |=> !pending_q);
  // R6: a tick with a pending word loads it and clears the flag
  p_tick_loads_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (div_tick && pending_q && !cap_ok) |=> (!pending_q && active_q == $past(staged_q)));
  // R7: outputs move only after a divider boundary
  p_hold_between_ticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(div_tick && pending_q) |=> $stable(active_q));

endmodule

// File: rtl/synth_ctl_port.sv
module synth_ctl_port
  import synth_ctl_pkg::*;
#(
  parameter int unsigned PORT_N      = 4,
  parameter int unsigned RATIO_W     = 17,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_clk,
  input  logic               bus_data,
  input  logic               bus_en,
  input  logic               div_tick,
  output logic [RATIO_W-1:0] div_ratio,
  output logic               presc_en,
  output logic [REF_W-1:0]   ref_sel,
  output logic               cp_cur_hi,
  output logic               drive_off,
  output logic               test_mode,
  output logic [PORT_N-1:0]  port_out,
  output logic               update_pending
);

  localparam int unsigned WORD_W   = PORT_N + CTRL_N + RATIO_W;
  localparam int unsigned CTRL_LSB = RATIO_W;
  localparam int unsigned PORT_LSB = RATIO_W + CTRL_N;

  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic [2:0]        bus_s;
  logic [WORD_W-1:0] shift_word;
  logic              cap_ok;
  logic [WORD_W-1:0] active_word;
  ctl_bits_t         ctl;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  ctl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d_in  ({bus_clk, bus_en, bus_data}),
    .d_out (bus_s)
  );

  ctl_shift #(.WORD_W(WORD_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .s_clk  (bus_s[2]),
    .s_en   (bus_s[1]),
    .s_dat  (bus_s[0]),
    .word_q (shift_word),
    .cap_ok (cap_ok)
  );

  ctl_stage #(.WORD_W(WORD_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cap_ok    (cap_ok),
    .word_in   (shift_word),
    .div_tick  (div_tick),
    .active_q  (active_word),
    .pending_q (update_pending)
  );

  always_comb begin
    ctl       = ctl_bits_t'(active_word[CTRL_LSB +: CTRL_N]);
    div_ratio = active_word[RATIO_W-1:0];
    port_out  = active_word[PORT_LSB +: PORT_N];
    presc_en  = ctl.presc;
    ref_sel   = ctl.ref_sel;
    cp_cur_hi = ctl.cp_hi;
    drive_off = ctl.drv_off;
    test_mode = ctl.test;
  end

  // R1: control outputs are cleared while reset is held
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n_s |-> (active_word == '0 && !update_pending));

endmodule

// File: tb/synth_ctl_port_tb_top.sv
module synth_ctl_port_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_clk = 1'b0, bus_data = 1'b0, bus_en = 1'b0, div_tick = 1'b0;

  logic [16:0] w_ratio, n_ratio;
  logic        w_presc, n_presc, w_cp, n_cp, w_off, n_off, w_test, n_test;
  logic [2:0]  w_ref, n_ref;
  logic [3:0]  w_port;
  logic [1:0]  n_port;
  logic        w_pend, n_pend;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  synth_ctl_port #(.PORT_N(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_data(bus_data),
    .bus_en(bus_en), .div_tick(div_tick), .div_ratio(w_ratio),
    .presc_en(w_presc), .ref_sel(w_ref), .cp_cur_hi(w_cp), .drive_off(w_off),
    .test_mode(w_test), .port_out(w_port), .update_pending(w_pend));

  synth_ctl_port #(.PORT_N(2)) dut_n (
    .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_data(bus_data),
    .bus_en(bus_en), .div_tick(div_tick), .div_ratio(n_ratio),
    .presc_en(n_presc), .ref_sel(n_ref), .cp_cur_hi(n_cp), .drive_off(n_off),
    .test_mode(n_test), .port_out(n_port), .update_pending(n_pend));

  // Active outputs reassembled in the R2 layout.
  function automatic logic [31:0] wide_out();
    return {4'b0, w_port, w_test, w_off, w_cp, w_ref, w_presc, w_ratio};
  endfunction
  function automatic logic [31:0] narrow_out();
    return {6'b0, n_port, n_test, n_off, n_cp, n_ref, n_presc, n_ratio};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_pulse(input logic d);
    @(negedge clk) bus_data = d;
    repeat (3) @(negedge clk);
    bus_clk = 1'b1;
    repeat (3) @(negedge clk);
    bus_clk = 1'b0;
  endtask

  task automatic send(input logic [31:0] w, input int n);
    @(negedge clk) bus_en = 1'b1;
    repeat (4) @(negedge clk);
    for (int b = n - 1; b >= 0; b--) bus_pulse(w[b]);
    repeat (3) @(negedge clk);
    bus_en = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) div_tick = 1'b1;
    @(negedge clk) div_tick = 0;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] make_word(input int i, input int np);
    logic [3:0]  p  = 4'(i);
    logic [2:0]  r  = 3'(i % 8);
    logic [16:0] ra = 17'((i * 9973 + 5) % 131072);
    logic [31:0] w;
    w = {15'b0, ra};
    w[17] = p[3];          // prescaler
    w[20:18] = r;          // reference select
    w[21] = p[2];          // charge pump
    w[22] = p[1];          // drive off
    w[23] = p[0] ^ p[3];   // test
    if (np == 4) w[27:24] = p;
    else         w[25:24] = p[1:0];
    return w;
  endfunction

  initial begin
    logic [31:0] w_exp, n_exp, wd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    chk("R1 wide outputs", wide_out(), 32'h0);
    chk("R1 narrow outputs", narrow_out(), 32'h0);
    chk("R1 pending", {31'b0, w_pend | n_pend}, 32'h0);
    w_exp = 0; n_exp = 0;

    // R2/R4/R6/R7 sweep of 28-bit words; narrow instance sees a wrong length (R5)
    for (int i = 0; i < 16; i++) begin
      wd = make_word(i, 4);
      send(wd, 28);
      chk("R4 wide pending", {31'b0, w_pend}, 32'h1);
      chk("R5 narrow no pending", {31'b0, n_pend}, 32'h0);
      chk("R7 wide held before tick", wide_out(), w_exp);
      tick();
      w_exp = wd;
      chk("R6 wide applied on tick", wide_out(), w_exp);
      chk("R2 ref select", {29'b0, w_ref}, 32'(i % 8));
      chk("R2 port bits", {28'b0, w_port}, 32'(i));
      chk("R6 pending cleared", {31'b0, w_pend}, 32'h0);
      chk("R5 narrow unchanged", narrow_out(), n_exp);
    end

    // R7 tick with nothing pending
    tick();
    chk("R7 idle tick", wide_out(), w_exp);

    // R8 narrow 26-bit words; wide instance rejects them (R5)
    for (int i = 0; i < 4; i++) begin
      wd = make_word(i + 5, 2);
      send(wd, 26);
      chk("R8 narrow pending", {31'b0, n_pend}, 32'h1);
      chk("R5 wide no pending", {31'b0, w_pend}, 32'h0);
      tick();
      n_exp = wd;
      chk("R8 narrow applied", narrow_out(), n_exp);
      chk("R5 wide unchanged", wide_out(), w_exp);
    end

    // R5 one bit short and one bit long for the wide instance
    send(32'h1555_5555, 27);
    chk("R5 short pending", {31'b0, w_pend}, 32'h0);
    tick();
    chk("R5 short discarded", wide_out(), w_exp);
    send(32'h0AAA_AAAA, 29);
    chk("R5 long pending", {31'b0, w_pend}, 32'h0);
    tick();
    chk("R5 long discarded", wide_out(), w_exp);

    // R3 clocks while the strobe is low
    for (int k = 0; k < 30; k++) bus_pulse(1'b1);
    repeat (6) @(negedge clk);
    chk("R3 no pending from idle clocks", {31'b0, w_pend | n_pend}, 32'h0);
    tick();
    chk("R3 wide unchanged", wide_out(), w_exp);
    chk("R3 narrow unchanged", narrow_out(), n_exp);
    for (int k = 0; k < 5; k++) bus_pulse(1'b0);
    wd = make_word(11, 4);
    send(wd, 28);
    tick();
    w_exp = wd;
    chk("R3 word after idle clocks", wide_out(), w_exp);

    // R9 two words before a tick: last one wins
    send(make_word(3, 4), 28);
    wd = make_word(12, 4);
    send(wd, 28);
    chk("R9 held before tick", wide_out(), w_exp);
    tick();
    w_exp = wd;
    chk("R9 last word applied", wide_out(), w_exp);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule